// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block chooses the two operand values, A and B, that the decode stage of a five-stage pipeline passes on to execute. The decode stage gives it two source register IDs and the data read from the register file for them. Later stages report which registers they are about to write and the values they will write. These are the ALU result now leaving execute, the ALU result and loaded value held in the memory stage, and the ALU result and loaded value held in write-back. For each operand the block takes the value from the youngest in-flight writer of that register. If no writer is in flight, it passes the register-file data through unchanged.

The block is purely combinational and has no state. The ID with all bits set is the "no register" code. It never matches, so missing operands and cancelled writes cause no forwarding. The execute stage reports its ALU destination after a failed conditional move has already been changed to this code. For call and jump instructions, operand A carries the incremented PC and no forwarded value.

Top module: `operand_bypass`

## Requirements
- R1: When no stage destination equals a source ID, that operand equals its register-file read data.
- R2: When the execute ALU destination equals the source ID, the operand is the execute ALU value, whatever the other stages hold.
- R3: When the memory-stage load destination matches and execute does not, the operand is the memory load value.
- R4: When the memory-stage ALU destination matches and neither execute nor memory load does, the operand is the memory ALU value.
- R5: When the write-back load destination matches and no execute or memory destination does, the operand is the write-back load value, even if the write-back ALU destination also matches.
- R6: When only the write-back ALU destination matches, the operand is the write-back ALU value.
- R7: A source ID of 4'hF (all ones) matches nothing: the operand is the register-file data even when destinations are also 4'hF.
- R8: When `dec_link` is 1, `opnd_a` equals `dec_pc_inc` regardless of any match, and `opnd_b` is unaffected.
- R9: Operands A and B are resolved independently, each by its own source ID against the same five destinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | 4 | Source register ID for operand A |
| dec_src_b | input | 4 | Source register ID for operand B |
| dec_link | input | 1 | Call/jump: operand A takes the incremented PC |
| dec_pc_inc | input | 32 | Incremented PC of the decode instruction |
| rf_data_a | input | 32 | Register-file read data for operand A |
| rf_data_b | input | 32 | Register-file read data for operand B |
| ex_alu_dst | input | 4 | Execute-stage ALU destination ID |
| ex_alu_val | input | 32 | ALU result being computed in execute |
| mem_alu_dst | input | 4 | Memory-stage ALU destination ID |
| mem_alu_val | input | 32 | Memory-stage ALU result |
| mem_ld_dst | input | 4 | Memory-stage load destination ID |
| mem_ld_val | input | 32 | Value just read from data memory |
| wb_alu_dst | input | 4 | Write-back ALU destination ID |
| wb_alu_val | input | 32 | Write-back ALU result |
| wb_ld_dst | input | 4 | Write-back load destination ID |
| wb_ld_val | input | 32 | Write-back loaded value |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |

## Verification
Every source ID, including 4'hF, is swept for operand A. Each of the five destinations is set independently to A's ID, B's ID or 4'hF, so every subset of matching stages appears and any priority inversion between two stages shows up as a wrong value. Operand B is tried with the same ID as A, a neighbouring ID and the no-register code, which separates independent resolution from shared matching. Each pattern is applied with the link select both clear and set, which shows that the PC override wins over forwarding and leaves B untouched. Every source drives a distinct value that is tagged with the vector number, so a wrong selection cannot pass unnoticed.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  dec_src_a,
  input  logic [REG_W-1:0]  dec_src_b,
  input  logic              dec_link,
  input  logic [DATA_W-1:0] dec_pc_inc,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic [REG_W-1:0]  ex_alu_dst,
  input  logic [DATA_W-1:0] ex_alu_val,
  input  logic [REG_W-1:0]  mem_alu_dst,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [REG_W-1:0]  mem_ld_dst,
  input  logic [DATA_W-1:0] mem_ld_val,
  input  logic [REG_W-1:0]  wb_alu_dst,
  input  logic [DATA_W-1:0] wb_alu_val,
  input  logic [REG_W-1:0]  wb_ld_dst,
  input  logic [DATA_W-1:0] wb_ld_val,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam logic [REG_W-1:0] NO_REG = '1;
  localparam int NSRC = 5;
  localparam int NOPS = 2;

  // index order is priority order: youngest producer first
  logic [REG_W-1:0]  dst [NSRC];
  logic [DATA_W-1:0] val [NSRC];
  assign dst[0] = ex_alu_dst;   assign val[0] = ex_alu_val;
  assign dst[1] = mem_ld_dst;   assign val[1] = mem_ld_val;
  assign dst[2] = mem_alu_dst;  assign val[2] = mem_alu_val;
  assign dst[3] = wb_ld_dst;    assign val[3] = wb_ld_val;
  assign dst[4] = wb_alu_dst;   assign val[4] = wb_alu_val;

  logic [REG_W-1:0]  src [NOPS];
  logic [DATA_W-1:0] rfd [NOPS];
  logic [DATA_W-1:0] fwd [NOPS];
  assign src[0] = dec_src_a;  assign rfd[0] = rf_data_a;
  assign src[1] = dec_src_b;  assign rfd[1] = rf_data_b;

  for (genvar k = 0; k < NOPS; k++) begin : g_opnd
    logic [NSRC-1:0]   hit;
    logic [DATA_W-1:0] pick;

    for (genvar j = 0; j < NSRC; j++) begin : g_cmp
      assign hit[j] = (src[k] != NO_REG) && (dst[j] == src[k]);
    end

    always_comb begin
      pick = rfd[k];
      for (int j = NSRC - 1; j >= 0; j--)
        if (hit[j]) pick = val[j];
    end

    assign fwd[k] = pick;
  end

  assign opnd_a = dec_link ? dec_pc_inc : fwd[0];
  assign opnd_b = fwd[1];

endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  dec_src_a,
  input logic [REG_W-1:0]  dec_src_b,
  input logic              dec_link,
  input logic [DATA_W-1:0] dec_pc_inc,
  input logic [DATA_W-1:0] rf_data_a,
  input logic [DATA_W-1:0] rf_data_b,
  input logic [REG_W-1:0]  ex_alu_dst,
  input logic [DATA_W-1:0] ex_alu_val,
  input logic [REG_W-1:0]  mem_alu_dst,
  input logic [REG_W-1:0]  mem_ld_dst,
  input logic [REG_W-1:0]  wb_alu_dst,
  input logic [REG_W-1:0]  wb_ld_dst,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);
  localparam logic [REG_W-1:0] NONE = '1;

  logic b_any;
  assign b_any = (ex_alu_dst == dec_src_b) || (mem_alu_dst == dec_src_b) ||
                 (mem_ld_dst == dec_src_b) || (wb_alu_dst == dec_src_b) ||
                 (wb_ld_dst == dec_src_b);

  always_comb begin
    AST_LINK_OVERRIDES: assert (!dec_link || opnd_a == dec_pc_inc); // R8
    AST_NONE_A_READS_RF: assert (dec_link || dec_src_a != NONE || opnd_a == rf_data_a); // R7
    AST_NONE_B_READS_RF: assert (dec_src_b != NONE || opnd_b == rf_data_b); // R7
    AST_EX_FIRST_A: assert (dec_link || dec_src_a == NONE || ex_alu_dst != dec_src_a
                            || opnd_a == ex_alu_val); // R2
    AST_EX_FIRST_B: assert (dec_src_b == NONE || ex_alu_dst != dec_src_b
                            || opnd_b == ex_alu_val); // R2
    AST_NO_MATCH_B: assert (b_any || opnd_b == rf_data_b); // R1
  end
endmodule

bind operand_bypass operand_bypass_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
  .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_link(dec_link),
  .dec_pc_inc(dec_pc_inc), .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
  .ex_alu_dst(ex_alu_dst), .ex_alu_val(ex_alu_val), .mem_alu_dst(mem_alu_dst),
  .mem_ld_dst(mem_ld_dst), .wb_alu_dst(wb_alu_dst), .wb_ld_dst(wb_ld_dst),
  .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/operand_bypass_tb_top.sv
module operand_bypass_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  src_a, src_b, d_ex, d_mal, d_mld, d_wal, d_wld;
  logic        link;
  logic [31:0] pc_inc, rf_a, rf_b, v_ex, v_mal, v_mld, v_wal, v_wld;
  logic [31:0] opnd_a, opnd_b;

  operand_bypass dut_i (
    .dec_src_a(src_a), .dec_src_b(src_b), .dec_link(link), .dec_pc_inc(pc_inc),
    .rf_data_a(rf_a), .rf_data_b(rf_b),
    .ex_alu_dst(d_ex), .ex_alu_val(v_ex), .mem_alu_dst(d_mal), .mem_alu_val(v_mal),
    .mem_ld_dst(d_mld), .mem_ld_val(v_mld), .wb_alu_dst(d_wal), .wb_alu_val(v_wal),
    .wb_ld_dst(d_wld), .wb_ld_val(v_wld), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  int  n_vec = 0, n_bad = 0;
  bit  finished = 0;

  task automatic model(input logic [3:0] s, input logic [31:0] rf,
                       output logic [31:0] v, output string tag);
    if (s == 4'hF)        begin v = rf;    tag = "R7"; end
    else if (d_ex  == s)  begin v = v_ex;  tag = "R2"; end
    else if (d_mld == s)  begin v = v_mld; tag = "R3"; end
    else if (d_mal == s)  begin v = v_mal; tag = "R4"; end
    else if (d_wld == s)  begin v = v_wld; tag = "R5"; end
    else if (d_wal == s)  begin v = v_wal; tag = "R6"; end
    else                  begin v = rf;    tag = "R1"; end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s vec %0d: got %h expected %h", tag, n_vec, act, exp);
    end
  endtask

  task automatic apply_and_check();
    logic [31:0] ea, eb;
    string ta, tb;
    @(posedge clk);
    @(negedge clk);
    model(src_a, rf_a, ea, ta);
    model(src_b, rf_b, eb, tb);
    if (link) begin ea = pc_inc; ta = "R8"; end
    check({ta, " opnd_a"}, opnd_a, ea);
    check({"R9/", tb, " opnd_b"}, opnd_b, eb);
  endtask

  function automatic logic [3:0] pick(input int sel, input logic [3:0] a, input logic [3:0] b);
    return (sel == 0) ? a : (sel == 1) ? b : 4'hF;
  endfunction

  initial begin
    // idle pattern: every ID is the no-register code, all reads come from the file
    src_a = 4'hF; src_b = 4'hF; link = 0;
    d_ex = 4'hF; d_mal = 4'hF; d_mld = 4'hF; d_wal = 4'hF; d_wld = 4'hF;
    pc_inc = 32'h0000_0044; rf_a = 32'hAAAA_0000; rf_b = 32'hBBBB_0000;
    v_ex = 32'h1; v_mal = 32'h2; v_mld = 32'h3; v_wal = 32'h4; v_wld = 32'h5;
    apply_and_check();  // R7 reset/idle state

    for (int sa = 0; sa < 16; sa++)
      for (int bs = 0; bs < 3; bs++)
        for (int combo = 0; combo < 243; combo++)
          for (int lk = 0; lk < 2; lk++) begin
            int c = combo;
            logic [3:0] sb;
            sb = (bs == 0) ? sa[3:0] : (bs == 1) ? sa[3:0] ^ 4'h1 : 4'hF;
            src_a = sa[3:0]; src_b = sb; link = lk[0];
            d_ex  = pick(c % 3, sa[3:0], sb); c = c / 3;
            d_mld = pick(c % 3, sa[3:0], sb); c = c / 3;
            d_mal = pick(c % 3, sa[3:0], sb); c = c / 3;
            d_wld = pick(c % 3, sa[3:0], sb); c = c / 3;
            d_wal = pick(c % 3, sa[3:0], sb);
            pc_inc = 32'h9000_0000 | n_vec;
            rf_a   = 32'hA000_0000 | n_vec;
            rf_b   = 32'hB000_0000 | n_vec;
            v_ex   = 32'h1000_0000 | n_vec;
            v_mld  = 32'h2000_0000 | n_vec;
            v_mal  = 32'h3000_0000 | n_vec;
            v_wld  = 32'h4000_0000 | n_vec;
            v_wal  = 32'h5000_0000 | n_vec;
            apply_and_check();
          end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule